// File: doc/BRIEF.md
# Register-Write Command List Executor

This block is a display-side DMA engine that plays back a list of register writes held in memory. Software turns the engine on, places a head pointer, and then writes a tail pointer to launch execution. The engine reads the list as 64-bit instruction words. It starts at head and moves upward, decodes each word, and drives the resulting writes onto a register bus with a valid/ready handshake. The engine only ever writes registers. It never reads them.

Two kinds of instruction exist. A direct write carries one value, a register offset and byte enables. An indexed write carries a count and one offset, followed by that many values. All of those values go to the same auto-increment register. The list is kept on 8-byte boundaries, so an indexed write with an odd count ends in a pad dword that the engine skips. Zero words between the last instruction and the cacheline-aligned tail do nothing. An unrecognised opcode halts the engine and raises a sticky error flag.

Top module: `cmdx_exec`

## Requirements
- R1: After reset, the enable, busy and error status outputs are 0, and neither `memReqValid` nor `regWrValid` is asserted.
- R2: The configuration bus has three addresses: 0 is control, 1 is head and 2 is tail. In the control word, bit 0 is the enable and bit 1 is an error clear (write 1 to clear). A write to head or tail is ignored unless the engine is enabled and not busy. A write to control is ignored while the engine is busy.
- R3: An accepted tail write takes effect as follows:
  - The engine forces the low 6 bits of the tail address and the low 3 bits of the head address to zero.
  - If the aligned tail differs from head, busy reads 1 on the cycle after the write.
  - If the aligned tail equals head, busy stays 0.
  - Busy falls only when the fetch address reaches tail, or when an error occurs. While busy is 0, no memory request and no register write is issued.
- R4: Memory reads are 8-byte aligned. Their addresses run upward from head in steps of 8 and end at the last word below tail. At most one read is outstanding at a time. In each response, bits 31:0 hold the even dword and bits 63:32 hold the odd dword.
- R5: Opcode 0x01, in bits 31:24 of the odd dword, is a direct write. It writes the even dword to the register offset in bits 19:0, using the byte enables in bits 23:20.
- R6: Opcode 0x09 is an indexed write. The even dword holds a count N, and bits 19:0 of the odd dword hold the offset. The next N dwords are written in order to that offset with byte enables 0xF. When N is odd, the pad dword that follows is skipped. When N is 0, nothing is written.
- R7: A word whose opcode is 0x00 produces no write, and execution continues. A zero-filled tail region therefore has no effect.
- R8: Any other opcode produces the following:
  - The error flag is set.
  - No write is made for that word.
  - No further fetch is made.
  - Busy clears.
  - The error flag stays set until a control write with bit 1 set is accepted.
- R9: While `regWrValid` is high and `regWrReady` is low, `regWrValid` stays high and the address, data and byte enables do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register select (0 control, 1 head, 2 tail) |
| cfgWrData | input | 32 | Configuration write data |
| ctrlEnable | output | 1 | Enable bit as currently held |
| ctrlBusy | output | 1 | Engine is executing a list |
| ctrlError | output | 1 | Sticky unknown-opcode flag |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Byte address of the 64-bit word to read |
| memRspValid | input | 1 | Read data valid, one cycle |
| memRspData | input | 64 | Read data, even dword in bits 31:0 |
| regWrValid | output | 1 | Register write valid |
| regWrReady | input | 1 | Register bus accepts the write |
| regWrAddr | output | 20 | Register offset |
| regWrData | output | 32 | Register write value |
| regWrBe | output | 4 | Byte enables |

## Verification
The hardest situation to reach is a register-bus stall in the middle of an indexed burst. The burst values alternate between the low and high halves of successive fetched words, and the count may end on either half, with or without a pad. To reach it, the stimulus builds many random lists that mix direct writes, indexed writes with counts of 0 to 6, and zero words. These lists run under random memory latency and a random write-ready, so stalls land on every burst phase. Directed lists cover the unknown-opcode halt and the error clear, configuration writes that arrive while the engine is busy or disabled, an unaligned tail, and a tail equal to head.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

  localparam int DWORD_W   = 32;
  localparam int WORD_W    = 64;
  localparam int REG_OFF_W = 20;
  localparam int BE_W      = 4;

  localparam logic [7:0] OP_NOP     = 8'h00;
  localparam logic [7:0] OP_DIRECT  = 8'h01;
  localparam logic [7:0] OP_INDEXED = 8'h09;

  localparam logic [1:0] CFG_CTRL = 2'd0;
  localparam logic [1:0] CFG_HEAD = 2'd1;
  localparam logic [1:0] CFG_TAIL = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DECODE,
    ST_DIRECT,
    ST_BURST_LO,
    ST_BURST_HI
  } execState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic advance;    // fetch pointer steps one word
    logic capture;    // latch the returned memory word
    logic loadBurst;  // latch count and offset of an indexed header
    logic decCount;   // one burst value consumed
    logic setError;   // unknown opcode seen
    logic finish;     // drop busy
    logic wrBurst;    // write uses burst offset and full byte enables
    logic wrHi;       // write takes the odd dword of the word
  } execStrobes_t;

endpackage

// File: rtl/cmdx_datapath.sv
module cmdx_datapath
  import cmdx_pkg::*;
#(
  parameter int ADDR_W     = 32,  // must not exceed DWORD_W
  parameter int LINE_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [1:0]           cfgAddr,
  input  logic [DWORD_W-1:0]   cfgWrData,
  input  execStrobes_t         strobe,
  input  logic [WORD_W-1:0]    memRspData,
  output logic                 ctrlEnable,
  output logic                 ctrlBusy,
  output logic                 ctrlError,
  output logic                 fetchAtTail,
  output logic [ADDR_W-1:0]    memReqAddr,
  output logic [7:0]           opcode,
  output logic                 hdrCountZero,
  output logic                 countIsOne,
  output logic [REG_OFF_W-1:0] regWrAddr,
  output logic [DWORD_W-1:0]   regWrData,
  output logic [BE_W-1:0]      regWrBe
);

  localparam int LINE_LSB  = $clog2(LINE_BYTES);
  localparam int INSTR_LSB = 3;
  localparam logic [ADDR_W-1:0] INSTR_STEP = ADDR_W'(8);

  logic                 enableReg, busyReg, errorReg;
  logic [ADDR_W-1:0]    headPtr, tailPtr, fetchPtr;
  logic [WORD_W-1:0]    wordReg;
  logic [REG_OFF_W-1:0] burstOff;
  logic [DWORD_W-1:0]   burstCnt;

  logic ctrlWr, headWr, tailWr;
  logic [ADDR_W-1:0] alignedHead, alignedTail;
  logic unusedCfgBit;

  assign ctrlWr = cfgWrEn && (cfgAddr == CFG_CTRL) && !busyReg;
  assign headWr = cfgWrEn && (cfgAddr == CFG_HEAD) && enableReg && !busyReg;
  assign tailWr = cfgWrEn && (cfgAddr == CFG_TAIL) && enableReg && !busyReg;

  assign alignedHead  = {cfgWrData[ADDR_W-1:INSTR_LSB], {INSTR_LSB{1'b0}}};
  assign alignedTail  = {cfgWrData[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
  assign unusedCfgBit = cfgWrData[2];

  // Control and status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      busyReg   <= 1'b0;
      errorReg  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enableReg <= cfgWrData[0];
        if (cfgWrData[1]) errorReg <= 1'b0;
      end
      if (strobe.setError) errorReg <= 1'b1;
      if (tailWr) busyReg <= (alignedTail != headPtr);
      else if (strobe.finish) busyReg <= 1'b0;
    end
  end

  // Pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      fetchPtr <= '0;
    end else begin
      if (headWr) headPtr <= alignedHead;
      if (tailWr) begin
        tailPtr  <= alignedTail;
        fetchPtr <= headPtr;
      end else if (strobe.advance) begin
        fetchPtr <= fetchPtr + INSTR_STEP;
      end
    end
  end

  // Instruction word and burst state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordReg  <= '0;
      burstOff <= '0;
      burstCnt <= '0;
    end else begin
      if (strobe.capture) wordReg <= memRspData;
      if (strobe.loadBurst) begin
        burstOff <= wordReg[32 +: REG_OFF_W];
        burstCnt <= wordReg[DWORD_W-1:0];
      end else if (strobe.decCount) begin
        burstCnt <= burstCnt - DWORD_W'(1);
      end
    end
  end

  assign ctrlEnable   = enableReg;
  assign ctrlBusy     = busyReg;
  assign ctrlError    = errorReg;
  assign fetchAtTail  = (fetchPtr == tailPtr);
  assign memReqAddr   = fetchPtr;
  assign opcode       = wordReg[63:56];
  assign hdrCountZero = (wordReg[DWORD_W-1:0] == '0);
  assign countIsOne   = (burstCnt == DWORD_W'(1));

  assign regWrAddr = strobe.wrBurst ? burstOff : wordReg[32 +: REG_OFF_W];
  assign regWrData = strobe.wrHi ? wordReg[WORD_W-1:DWORD_W] : wordReg[DWORD_W-1:0];
  assign regWrBe   = strobe.wrBurst ? {BE_W{1'b1}} : wordReg[52 +: BE_W];

endmodule

// File: rtl/cmdx_control.sv
module cmdx_control
  import cmdx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busy,
  input  logic         fetchAtTail,
  input  logic [7:0]   opcode,
  input  logic         hdrCountZero,
  input  logic         countIsOne,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         regWrReady,
  output execStrobes_t strobe,
  output logic         memReqValid,
  output logic         regWrValid
);

  execState_t state, stateNext;
  logic inBurst, setBurst, clrBurst;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    memReqValid = 1'b0;
    regWrValid  = 1'b0;
    setBurst    = 1'b0;
    clrBurst    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (busy) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (fetchAtTail) begin
          strobe.finish = 1'b1;
          clrBurst      = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          memReqValid = 1'b1;
          if (memReqReady) begin
            strobe.advance = 1'b1;
            stateNext      = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (memRspValid) begin
          strobe.capture = 1'b1;
          stateNext      = inBurst ? ST_BURST_LO : ST_DECODE;
        end
      end
      ST_DECODE: begin
        case (opcode)
          OP_NOP:    stateNext = ST_REQ;
          OP_DIRECT: stateNext = ST_DIRECT;
          OP_INDEXED: begin
            strobe.loadBurst = 1'b1;
            setBurst         = !hdrCountZero;
            stateNext        = ST_REQ;
          end
          default: begin
            strobe.setError = 1'b1;
            strobe.finish   = 1'b1;
            stateNext       = ST_IDLE;
          end
        endcase
      end
      ST_DIRECT: begin
        regWrValid = 1'b1;
        if (regWrReady) stateNext = ST_REQ;
      end
      ST_BURST_LO: begin
        regWrValid     = 1'b1;
        strobe.wrBurst = 1'b1;
        if (regWrReady) begin
          strobe.decCount = 1'b1;
          if (countIsOne) begin
            clrBurst  = 1'b1;   // odd dword of this word is the pad
            stateNext = ST_REQ;
          end else begin
            stateNext = ST_BURST_HI;
          end
        end
      end
      ST_BURST_HI: begin
        regWrValid     = 1'b1;
        strobe.wrBurst = 1'b1;
        strobe.wrHi    = 1'b1;
        if (regWrReady) begin
          strobe.decCount = 1'b1;
          clrBurst        = countIsOne;
          stateNext       = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      inBurst <= 1'b0;
    end else begin
      state <= stateNext;
      if (clrBurst) inBurst <= 1'b0;
      else if (setBurst) inBurst <= 1'b1;
    end
  end

endmodule

// File: rtl/cmdx_exec.sv
module cmdx_exec
  import cmdx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [1:0]           cfgAddr,
  input  logic [31:0]          cfgWrData,
  output logic                 ctrlEnable,
  output logic                 ctrlBusy,
  output logic                 ctrlError,
  output logic                 memReqValid,
  input  logic                 memReqReady,
  output logic [ADDR_W-1:0]    memReqAddr,
  input  logic                 memRspValid,
  input  logic [63:0]          memRspData,
  output logic                 regWrValid,
  input  logic                 regWrReady,
  output logic [19:0]          regWrAddr,
  output logic [31:0]          regWrData,
  output logic [3:0]           regWrBe
);

  execStrobes_t strobe;
  logic fetchAtTail, hdrCountZero, countIsOne;
  logic [7:0] opcode;

  cmdx_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_datapath (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .strobe(strobe), .memRspData(memRspData),
    .ctrlEnable(ctrlEnable), .ctrlBusy(ctrlBusy), .ctrlError(ctrlError),
    .fetchAtTail(fetchAtTail), .memReqAddr(memReqAddr), .opcode(opcode),
    .hdrCountZero(hdrCountZero), .countIsOne(countIsOne),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regWrBe(regWrBe)
  );

  cmdx_control u_control (
    .clk(clk), .rstN(rstN),
    .busy(ctrlBusy), .fetchAtTail(fetchAtTail), .opcode(opcode),
    .hdrCountZero(hdrCountZero), .countIsOne(countIsOne),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .regWrReady(regWrReady),
    .strobe(strobe), .memReqValid(memReqValid), .regWrValid(regWrValid)
  );

endmodule

// File: rtl/cmdx_checker.sv
module cmdx_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [1:0]        cfgAddr,
  input logic [31:0]       cfgWrData,
  input logic              ctrlBusy,
  input logic              ctrlError,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              regWrValid,
  input logic              regWrReady,
  input logic [19:0]       regWrAddr,
  input logic [31:0]       regWrData,
  input logic [3:0]        regWrBe
);

  logic [1:0] outstanding;
  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= '0;
    else outstanding <= outstanding + 2'(memReqValid && memReqReady) - 2'(memRspValid);
  end

  AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBusy |-> !memReqValid && !regWrValid);  // R3

  AST_START_BY_TAIL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlBusy) |-> $past(cfgWrEn && cfgAddr == 2'd2));  // R3

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000);  // R4

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> outstanding == 2'd0);  // R4

  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    regWrValid && !regWrReady |=> regWrValid && $stable(regWrAddr)
      && $stable(regWrData) && $stable(regWrBe));  // R9

  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ctrlError && !(cfgWrEn && cfgAddr == 2'd0 && cfgWrData[1]) |=> ctrlError);  // R8

  AST_ERROR_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlError) |-> !ctrlBusy);  // R8

endmodule

bind cmdx_exec cmdx_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
  .ctrlBusy(ctrlBusy), .ctrlError(ctrlError),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .regWrValid(regWrValid), .regWrReady(regWrReady),
  .regWrAddr(regWrAddr), .regWrData(regWrData), .regWrBe(regWrBe)
);

// File: tb/cmdx_exec_bench.sv
`timescale 1ns/1ps
module cmdx_exec_bench;

  localparam int MEM_DW = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        ctrlEnable, ctrlBusy, ctrlError;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        regWrValid;
  logic        regWrReady = 1'b0;
  logic [19:0] regWrAddr;
  logic [31:0] regWrData;
  logic [3:0]  regWrBe;

  always #2.5 clk = ~clk;

  cmdx_exec u_cmdx_exec (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .ctrlEnable(ctrlEnable), .ctrlBusy(ctrlBusy), .ctrlError(ctrlError),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .regWrValid(regWrValid), .regWrReady(regWrReady),
    .regWrAddr(regWrAddr), .regWrData(regWrData), .regWrBe(regWrBe)
  );

  int checkCnt = 0;
  int failCnt  = 0;

  logic [31:0] mem [0:MEM_DW-1];
  logic [55:0] expWr [0:1023];
  logic [55:0] gotWr [0:1023];
  int expCnt = 0;
  int gotCnt = 0;
  int wp = 0;
  int fetchErr = 0;
  int stallErr = 0;
  logic [31:0] fetchExp = '0;
  int readyPct = 75;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Memory model: random ready, 0..2 cycles of latency
  initial begin : memModel
    bit havePend = 0;
    int pendDelay = 0;
    logic [31:0] pendAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (havePend) begin
        if (pendDelay == 0) begin
          memRspValid = 1'b1;
          memRspData  = {mem[pendAddr[12:2] + 11'd1], mem[pendAddr[12:2]]};
          havePend    = 0;
        end else pendDelay--;
      end
      memReqReady = ($urandom % 100) < 70;
      if (memReqValid && memReqReady) begin
        if (memReqAddr != fetchExp) fetchErr++;
        fetchExp  = fetchExp + 32'd8;
        havePend  = 1;
        pendAddr  = memReqAddr;
        pendDelay = $urandom % 3;
      end
    end
  end

  // Register write sink with random ready and stall-stability monitor
  initial begin : wrSink
    bit prevStall = 0;
    logic [55:0] prevWr = '0;
    forever begin
      @(negedge clk);
      if (prevStall && (!regWrValid || {regWrAddr, regWrData, regWrBe} != prevWr))
        stallErr++;
      regWrReady = ($urandom % 100) < readyPct;
      if (regWrValid && regWrReady && gotCnt < 1024) begin
        gotWr[gotCnt] = {regWrAddr, regWrData, regWrBe};
        gotCnt++;
      end
      prevStall = regWrValid && !regWrReady;
      prevWr    = {regWrAddr, regWrData, regWrBe};
    end
  end

  task automatic cfgWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic putDw(input logic [31:0] v);
    mem[wp] = v;
    wp++;
  endtask

  task automatic expPush(input logic [19:0] a, input logic [31:0] d, input logic [3:0] be);
    expWr[expCnt] = {a, d, be};
    expCnt++;
  endtask

  task automatic newList(input logic [31:0] headB);
    for (int i = 0; i < MEM_DW; i++) mem[i] = '0;
    wp = int'(headB >> 2);
    expCnt = 0;
  endtask

  task automatic addDirect(input logic [19:0] off, input logic [3:0] be, input logic [31:0] d);
    putDw(d);
    putDw({8'h01, be, off});
    expPush(off, d, be);
  endtask

  task automatic addIndexed(input logic [19:0] off, input int n);
    putDw(32'(n));
    putDw({8'h09, 4'h0, off});
    for (int i = 0; i < n; i++) begin
      logic [31:0] v;
      v = $urandom;
      putDw(v);
      expPush(off, v, 4'hF);
    end
    if (n % 2 == 1) putDw(32'h0);
  endtask

  task automatic addNop();
    putDw(32'h0);
    putDw(32'h0);
  endtask

  function automatic logic [31:0] listTail();
    return 32'(((wp + 15) / 16) * 64);
  endfunction

  // Runs a prepared list; tailW may carry low bits that must be ignored (R3)
  task automatic runList(input logic [31:0] headB, input logic [31:0] tailW, input string tag);
    logic [31:0] tailEnd;
    int waitCyc;
    tailEnd = tailW & ~32'h3F;
    cfgWrite(2'd1, headB);
    gotCnt = 0; fetchErr = 0; stallErr = 0; fetchExp = headB;
    cfgWrite(2'd2, tailW);
    chk(ctrlBusy == 1'b1, "R3", "busy after tail write", ctrlBusy, 1);
    waitCyc = 0;
    while (ctrlBusy && waitCyc < 20000) begin
      @(negedge clk);
      waitCyc++;
    end
    repeat (2) @(negedge clk);
    chk(ctrlBusy == 1'b0, "R3", "busy clears at tail", ctrlBusy, 0);
    chk(gotCnt == expCnt, tag, "write count", gotCnt, expCnt);
    for (int i = 0; i < expCnt && i < gotCnt; i++)
      chk(gotWr[i] == expWr[i], tag, "write addr/data/be", gotWr[i], expWr[i]);
    chk(fetchErr == 0 && fetchExp == tailEnd, "R4", "fetch sequence end",
        fetchExp, tailEnd);
    chk(stallErr == 0, "R9", "write held during stall", stallErr, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", failCnt, checkCnt);
    $finish;
  end

  initial begin : main
    logic [31:0] tl;
    logic [31:0] hd;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < MEM_DW; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(ctrlEnable == 0, "R1", "enable", ctrlEnable, 0);
    chk(ctrlBusy == 0, "R1", "busy", ctrlBusy, 0);
    chk(ctrlError == 0, "R1", "error", ctrlError, 0);
    chk(memReqValid == 0, "R1", "memReqValid", memReqValid, 0);
    chk(regWrValid == 0, "R1", "regWrValid", regWrValid, 0);

    // R2 head/tail ignored while disabled
    newList(32'h40);
    addDirect(20'h00123, 4'hF, 32'hDEAD_BEEF);
    cfgWrite(2'd1, 32'h40);
    cfgWrite(2'd2, 32'h80);
    repeat (4) @(negedge clk);
    chk(ctrlBusy == 0 && gotCnt == 0, "R2", "tail write while disabled", ctrlBusy, 0);

    cfgWrite(2'd0, 32'h1);
    chk(ctrlEnable == 1, "R2", "enable set", ctrlEnable, 1);

    // R3 tail equal to head: nothing runs
    cfgWrite(2'd1, 32'h80);
    cfgWrite(2'd2, 32'h80);
    repeat (4) @(negedge clk);
    chk(ctrlBusy == 0, "R3", "tail equals head stays idle", ctrlBusy, 0);

    // R5 direct writes with assorted byte enables, unaligned tail (R3)
    newList(32'h40);
    addDirect(20'hABCDE, 4'h3, 32'h1111_2222);
    addDirect(20'h00004, 4'hC, 32'h3333_4444);
    tl = listTail();
    runList(32'h40, tl | 32'h24, "R5");

    // R6 indexed writes: odd count with pad, even count, zero count
    newList(32'h48);
    addIndexed(20'h00700, 3);
    addIndexed(20'h00704, 2);
    addIndexed(20'h00708, 0);
    addIndexed(20'h0070C, 1);
    addDirect(20'h00010, 4'hF, 32'h5555_AAAA);
    runList(32'h48, listTail(), "R6");

    // R7 zero-opcode words between writes are skipped
    newList(32'h80);
    addNop();
    addDirect(20'h00020, 4'h1, 32'h0000_00A5);
    addNop();
    addNop();
    addIndexed(20'h00030, 2);
    runList(32'h80, listTail(), "R7");

    // Random lists under random stalls
    for (int n = 0; n < 10; n++) begin
      int items;
      hd = 32'(64 * ($urandom % 4) + 8 * ($urandom % 8));
      newList(hd);
      items = 1 + $urandom % 10;
      readyPct = 30 + $urandom % 70;
      for (int k = 0; k < items; k++) begin
        case ($urandom % 3)
          0: addDirect(20'($urandom), 4'($urandom), $urandom);
          1: addIndexed(20'($urandom), int'($urandom % 7));
          default: addNop();
        endcase
      end
      runList(hd, listTail(), "R6");
    end
    readyPct = 75;

    // R8 unknown opcode halts and sets sticky error
    newList(32'h40);
    addDirect(20'h00100, 4'hF, 32'h0BAD_0001);
    putDw(32'h1234_5678);
    putDw({8'h05, 24'h000200});
    addDirect(20'h00300, 4'hF, 32'h0BAD_0003);
    cfgWrite(2'd1, 32'h40);
    gotCnt = 0; fetchErr = 0; fetchExp = 32'h40;
    cfgWrite(2'd2, listTail());
    begin
      int waitCyc = 0;
      while (ctrlBusy && waitCyc < 5000) begin
        @(negedge clk);
        waitCyc++;
      end
    end
    repeat (6) @(negedge clk);
    chk(ctrlError == 1, "R8", "error flag set", ctrlError, 1);
    chk(ctrlBusy == 0, "R8", "busy cleared on error", ctrlBusy, 0);
    chk(gotCnt == 1, "R8", "only write before bad opcode", gotCnt, 1);
    chk(fetchExp == 32'h50, "R8", "no fetch after bad opcode", fetchExp, 32'h50);
    cfgWrite(2'd0, 32'h1);
    chk(ctrlError == 1, "R8", "error kept without clear bit", ctrlError, 1);
    cfgWrite(2'd0, 32'h3);
    chk(ctrlError == 0, "R8", "error cleared by bit 1", ctrlError, 0);
    chk(ctrlEnable == 1, "R2", "enable kept by clear write", ctrlEnable, 1);

    // R2 control write ignored while busy
    newList(32'h40);
    addIndexed(20'h00440, 40);
    readyPct = 20;
    cfgWrite(2'd1, 32'h40);
    gotCnt = 0; stallErr = 0; fetchExp = 32'h40;
    cfgWrite(2'd2, listTail());
    cfgWrite(2'd0, 32'h0);
    chk(ctrlBusy == 1, "R2", "still busy at control write", ctrlBusy, 1);
    begin
      int waitCyc = 0;
      while (ctrlBusy && waitCyc < 20000) begin
        @(negedge clk);
        waitCyc++;
      end
    end
    repeat (2) @(negedge clk);
    chk(ctrlEnable == 1, "R2", "control write during busy ignored", ctrlEnable, 1);
    chk(gotCnt == expCnt, "R6", "long burst count", gotCnt, expCnt);
    chk(stallErr == 0, "R9", "write held during stall", stallErr, 0);

    $display("Result: errors=%0d of %0d checks", failCnt, checkCnt);
    $finish;
  end

endmodule